// File: doc/BRIEF.md
# Trace Live-Output Value Predictor

This block is the prediction table for trace-level speculation. A trace is the stretch of instructions between two backward branches. The table is addressed by the address where a trace starts. A lookup asks whether the table can predict that trace. If it can, one cycle later the block returns the address where the trace ends, plus a value and a register id for each live output of the trace.

When the trace has actually run, an update carries the same start address, the real end address, the register ids and the real live-output values. These train the matching entry, or claim an entry if there is no match.

For each live output, an entry keeps the most recent values seen for that trace. Two predictors work from this history:
- A stride predictor carries the last change forward.
- A context predictor finds where the newest value last occurred and replays the value that came next.

Each predictor has its own saturating confidence counter. A lookup hits only when every live output has a confident predictor ready.

Top module: `trace_lo_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup returns rsp_hit = 0.
- R2: A request with lk_valid at a rising edge yields rsp_valid high after that same edge, for exactly one cycle per request. rsp_valid is low when no request was made, and rsp_hit is never high without rsp_valid.
- R3: With 32 sets, the set is pc[6:2]. The rest of the address (pc[31:7] and pc[1:0]) is the tag. Each set has 2 ways. A lookup hits only in a valid way whose tag matches.
- R4: An update whose tag is in neither way replaces the least recently trained way. Each set has one bit of recency, and only updates change it. An entry trained after a rival survives the next allocation in that set.
- R5: Each live output keeps its 9 most recent values. A repeating pattern with period 8 is learned by the context predictor. A pattern with period 9 is never learned.
- R6: The stride prediction is newest + (newest − previous), and it needs at least 2 stored values. Its 2-bit confidence counter works as follows:
  - It rises by one, saturating at 3, when an update's value equals the prediction made before that update.
  - It is cleared otherwise.
  - The stride predictor is confident at 3. A pure stride sequence therefore first hits after its fifth update.
- R7: The context prediction searches the stored history for the most recent earlier copy of the newest value, and predicts the value stored just after it. It is trained the same way as stride. A period-3 sequence first hits after its seventh update.
- R8: For each live output, the context prediction is used when its counter is 3 and a match exists. Otherwise the stride prediction is used when its counter is 3. If neither applies, the whole lookup misses.
- R9: A hit returns, in rsp_end_pc and rsp_reg_ids, the end address and register ids from the most recent update of that entry. Lane i of the vectors is bits [i*W +: W].
- R10: An update that neither predictor foresaw clears both counters, so the next lookup of that trace misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Trace start address to look up |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Every live output predicted confidently |
| rsp_end_pc | output | 32 | Predicted trace end address |
| rsp_reg_ids | output | 20 | Four 5-bit live-output register ids |
| rsp_vals | output | 128 | Four 32-bit predicted live-output values |
| up_valid | input | 1 | Training update |
| up_pc | input | 32 | Trace start address of the update |
| up_end_pc | input | 32 | Actual end address |
| up_reg_ids | input | 20 | Live-output register ids |
| up_vals | input | 128 | Actual live-output values |

## Verification
The hardest case to reach is the edge of the history depth. A period-8 pattern is found only once the history is completely full, and a period-9 pattern is just out of reach. The stimulus drives long periodic sequences through the update port and shows both sides:
- The period-8 trace misses after 11 updates and hits after 12, with the value computed for the 13th instance.
- The period-9 trace still misses after 20 updates.

Eviction is reached by training three traces that map to one set, in a chosen order. Lookups on all three then show which way was replaced.

// File: rtl/trace_lo_predictor.sv
module trace_lo_predictor #(
  parameter int PCW  = 32,
  parameter int SETS = 32,
  parameter int NLO  = 4,
  parameter int RW   = 5,
  parameter int DW   = 32,
  parameter int HIST = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [PCW-1:0]      lk_pc,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [PCW-1:0]      rsp_end_pc,
  output logic [NLO*RW-1:0]   rsp_reg_ids,
  output logic [NLO*DW-1:0]   rsp_vals,
  input  logic                up_valid,
  input  logic [PCW-1:0]      up_pc,
  input  logic [PCW-1:0]      up_end_pc,
  input  logic [NLO*RW-1:0]   up_reg_ids,
  input  logic [NLO*DW-1:0]   up_vals
);
  localparam int IW = $clog2(SETS);
  localparam int TW = PCW - IW;
  localparam int CW = $clog2(HIST + 1);
  localparam int HB = HIST * DW;

  logic            vld [SETS][2];
  logic [TW-1:0]   tg  [SETS][2];
  logic [PCW-1:0]  epc [SETS][2];
  logic [NLO*RW-1:0] rid [SETS][2];
  logic [HB-1:0]   hs  [SETS][2][NLO];
  logic [CW-1:0]   hn  [SETS][2];
  logic [1:0]      sc  [SETS][2][NLO];
  logic [1:0]      cc  [SETS][2][NLO];
  logic            lru [SETS];

  function automatic logic [DW:0] f_stride(input logic [HB-1:0] h, input logic [CW-1:0] n);
    logic [DW-1:0] a, b;
    a = h[DW-1:0];
    b = h[2*DW-1:DW];
    return {n >= CW'(2), a + (a - b)};
  endfunction

  function automatic logic [DW:0] f_ctx(input logic [HB-1:0] h, input logic [CW-1:0] n);
    logic ok;
    logic [DW-1:0] p;
    ok = 1'b0;
    p  = '0;
    for (int j = HIST - 1; j >= 1; j--)
      if (CW'(j) < n && h[j*DW +: DW] == h[DW-1:0]) begin
        ok = 1'b1;
        p  = h[(j-1)*DW +: DW];
      end
    return {ok, p};
  endfunction

  function automatic logic [1:0] f_inc(input logic [1:0] x);
    return (x == 2'd3) ? 2'd3 : x + 2'd1;
  endfunction

  wire [IW-1:0] li = lk_pc[IW+1:2];
  wire [TW-1:0] lt = {lk_pc[PCW-1:IW+2], lk_pc[1:0]};
  wire lh1 = vld[li][1] && tg[li][1] == lt;
  wire lh0 = vld[li][0] && tg[li][0] == lt;
  wire lw  = lh1;

  wire [IW-1:0] ui = up_pc[IW+1:2];
  wire [TW-1:0] ut = {up_pc[PCW-1:IW+2], up_pc[1:0]};
  wire uh1  = vld[ui][1] && tg[ui][1] == ut;
  wire uh0  = vld[ui][0] && tg[ui][0] == ut;
  wire uhit = uh0 | uh1;
  wire uw   = uhit ? uh1 : lru[ui];

  logic            l_hit;
  logic [NLO*DW-1:0] l_val;
  logic [NLO-1:0]  u_sok, u_cok;

  always_comb begin
    logic [DW:0] s, c;
    l_hit = lh0 | lh1;
    l_val = '0;
    for (int l = 0; l < NLO; l++) begin
      s = f_stride(hs[li][lw][l], hn[li][lw]);
      c = f_ctx(hs[li][lw][l], hn[li][lw]);
      if (cc[li][lw][l] == 2'd3 && c[DW]) l_val[l*DW +: DW] = c[DW-1:0];
      else if (sc[li][lw][l] == 2'd3 && s[DW]) l_val[l*DW +: DW] = s[DW-1:0];
      else l_hit = 1'b0;
    end
  end

  always_comb begin
    logic [DW:0] s, c;
    for (int l = 0; l < NLO; l++) begin
      s = f_stride(hs[ui][uw][l], hn[ui][uw]);
      c = f_ctx(hs[ui][uw][l], hn[ui][uw]);
      u_sok[l] = s[DW] && s[DW-1:0] == up_vals[l*DW +: DW];
      u_cok[l] = c[DW] && c[DW-1:0] == up_vals[l*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid & l_hit;
    end
    rsp_end_pc  <= epc[li][lw];
    rsp_reg_ids <= rid[li][lw];
    rsp_vals    <= l_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s][0] <= 1'b0;
        vld[s][1] <= 1'b0;
        lru[s]    <= 1'b0;
      end
    end else if (up_valid) begin
      vld[ui][uw] <= 1'b1;
      tg[ui][uw]  <= ut;
      epc[ui][uw] <= up_end_pc;
      rid[ui][uw] <= up_reg_ids;
      lru[ui]     <= ~uw;
      hn[ui][uw]  <= !uhit ? CW'(1) : (hn[ui][uw] == CW'(HIST)) ? CW'(HIST) : hn[ui][uw] + CW'(1);
      for (int l = 0; l < NLO; l++) begin
        hs[ui][uw][l] <= uhit ? {hs[ui][uw][l][HB-DW-1:0], up_vals[l*DW +: DW]}
                              : {{(HB-DW){1'b0}}, up_vals[l*DW +: DW]};
        sc[ui][uw][l] <= (uhit && u_sok[l]) ? f_inc(sc[ui][uw][l]) : 2'd0;
        cc[ui][uw][l] <= (uhit && u_cok[l]) ? f_inc(cc[ui][uw][l]) : 2'd0;
      end
    end
  end

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !rsp_valid);
  a_r2_hit_qualified: assert property (@(posedge clk) disable iff (!rst_n) rsp_hit |-> rsp_valid);
  a_r4_written_way: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> vld[$past(ui)][$past(uw)] && tg[$past(ui)][$past(uw)] == $past(ut)
                 && lru[$past(ui)] != $past(uw));
  a_r5_hist_bound: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> hn[$past(ui)][$past(uw)] >= CW'(1) && hn[$past(ui)][$past(uw)] <= CW'(HIST));
  a_r6_alloc_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !uhit) |=> hn[$past(ui)][$past(uw)] == CW'(1));
endmodule

// File: tb/sim_trace_lo_predictor.sv
`timescale 1ns/1ps
module sim_trace_lo_predictor;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, up_valid = 0;
  logic [31:0] lk_pc = 0, up_pc = 0, up_end_pc = 0;
  logic [19:0] up_reg_ids = 0;
  logic [127:0] up_vals = 0;
  logic rsp_valid, rsp_hit;
  logic [31:0] rsp_end_pc;
  logic [19:0] rsp_reg_ids;
  logic [127:0] rsp_vals;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trace_lo_predictor u0 (.clk, .rst_n, .lk_valid, .lk_pc, .rsp_valid, .rsp_hit,
    .rsp_end_pc, .rsp_reg_ids, .rsp_vals, .up_valid, .up_pc, .up_end_pc,
    .up_reg_ids, .up_vals);

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] v_str(input int k);
    logic [127:0] r;
    for (int l = 0; l < 4; l++) r[l*32 +: 32] = 32'(100*l + k*(l+1));
    return r;
  endfunction

  function automatic logic [127:0] v_per(input int k, input int p);
    logic [127:0] r;
    int m;
    m = k % p;
    for (int l = 0; l < 4; l++) r[l*32 +: 32] = 32'(7*m*m + 3 + 1000*l);
    return r;
  endfunction

  task automatic upd(input logic [31:0] pc, input logic [31:0] ep, input logic [19:0] ids, input logic [127:0] v);
    @(negedge clk);
    up_valid = 1; up_pc = pc; up_end_pc = ep; up_reg_ids = ids; up_vals = v;
    @(negedge clk);
    up_valid = 0;
  endtask

  task automatic look(input logic [31:0] pc, input bit eh, input logic [31:0] ep,
                      input logic [19:0] ids, input logic [127:0] ev, input string req);
    @(negedge clk);
    lk_valid = 1; lk_pc = pc;
    @(posedge clk); #1;
    lk_valid = 0;
    chk(rsp_valid === 1'b1, "R2 rsp_valid", 128'(rsp_valid), 128'(1));
    chk(rsp_hit === eh, req, 128'(rsp_hit), 128'(eh));
    if (eh) begin
      chk(rsp_vals === ev, {req, " values"}, rsp_vals, ev);
      chk(rsp_end_pc === ep, "R9 end pc", 128'(rsp_end_pc), 128'(ep));
      chk(rsp_reg_ids === ids, "R9 reg ids", 128'(rsp_reg_ids), 128'(ids));
    end
    @(posedge clk); #1;
    chk(rsp_valid === 1'b0, "R2 single pulse", 128'(rsp_valid), 128'(0));
  endtask

  initial begin
    #400000;
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: nothing valid after reset
    look(32'h1000, 0, 0, 0, 0, "R1 miss after reset");
    // R6: stride needs five updates
    for (int k = 0; k < 4; k++) upd(32'h1000, 32'h1040, 20'h12345, v_str(k));
    look(32'h1000, 0, 0, 0, 0, "R6 miss at four updates");
    upd(32'h1000, 32'h1040, 20'h12345, v_str(4));
    look(32'h1000, 1, 32'h1040, 20'h12345, v_str(5), "R6 stride hit");
    // R9: newest end pc and ids reported
    upd(32'h1000, 32'h1080, 20'hABCDE, v_str(5));
    look(32'h1000, 1, 32'h1080, 20'hABCDE, v_str(6), "R9 retrained hit");
    // R3: neighbouring set misses
    look(32'h1004, 0, 0, 0, 0, "R3 other set miss");
    // R10: unforeseen value clears confidence
    upd(32'h1000, 32'h1080, 20'hABCDE, v_str(7));
    look(32'h1000, 0, 0, 0, 0, "R10 miss after mispredict");
    // R7 R8: period-3 context pattern in second way of set 0
    for (int k = 0; k < 6; k++) upd(32'h2000, 32'h2100, 20'h0F0F0, v_per(k, 3));
    look(32'h2000, 0, 0, 0, 0, "R7 miss at six updates");
    upd(32'h2000, 32'h2100, 20'h0F0F0, v_per(6, 3));
    look(32'h2000, 1, 32'h2100, 20'h0F0F0, v_per(7, 3), "R7 R8 context hit");
    // R4: third trace in set 0 replaces least recently trained way (trace at 0x1000)
    upd(32'h3000, 32'h3050, 20'h11111, v_str(0));
    look(32'h1000, 0, 0, 0, 0, "R4 evicted trace misses");
    look(32'h2000, 1, 32'h2100, 20'h0F0F0, v_per(7, 3), "R4 recent trace kept");
    look(32'h3000, 0, 0, 0, 0, "R4 new trace not confident");
    // R5: period 8 fits the 9-deep history
    for (int k = 0; k < 11; k++) upd(32'h1104, 32'h1200, 20'h22222, v_per(k, 8));
    look(32'h1104, 0, 0, 0, 0, "R5 period 8 miss at eleven");
    upd(32'h1104, 32'h1200, 20'h22222, v_per(11, 8));
    look(32'h1104, 1, 32'h1200, 20'h22222, v_per(12, 8), "R5 period 8 hit");
    // R5: period 9 does not fit
    for (int k = 0; k < 20; k++) upd(32'h1108, 32'h1300, 20'h33333, v_per(k, 9));
    look(32'h1108, 0, 0, 0, 0, "R5 period 9 never learned");
    // R5 R6: long stride run past history depth
    for (int k = 0; k < 12; k++) upd(32'h110C, 32'h1400, 20'h44444, v_str(k));
    look(32'h110C, 1, 32'h1400, 20'h44444, v_str(12), "R5 R6 long stride hit");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule